// File: doc/BRIEF.md
# JTAG Test Access Port with Configuration Registers

This block is the serial test port of a small configurable device that has no boundary-scan chain. It runs the standard sixteen-state TAP controller from TCK and TMS, keeps an 8-bit instruction register, and uses the active instruction to pick which data register sits between TDI and TDO. The available data paths are a 1-bit bypass, a 32-bit identification register, a 32-bit user-signature register, a 4-bit configuration address register and a 56-bit configuration data register.

Opcodes that erase, program or verify the device have no shift path of their own. Each one becomes a one-cycle strobe on a command bus that a programming engine outside the block consumes. The nonvolatile storage and that engine are not part of this block. The two boundary-scan instructions are accepted, but they route through the bypass bit.

The test reset is a synchronous, active-high input sampled on TCK. A host can also return the controller to Test-Logic-Reset by holding TMS high for five clocks.

Top module: `tap_port`

## Requirements
- R1: After `tap_rst`, or after five TCK cycles with TMS high, the controller is in Test-Logic-Reset, `tdo_oe` is low, `cmd_pulse` is zero, and the active instruction is IDCODE (0x16).
- R2: With IDCODE active, a 32-bit data scan shifts out the `ID_VALUE` parameter LSB first, with no instruction scan needed after reset. Bit 0 of `ID_VALUE` is 1.
- R3: Capture-IR loads the instruction shift register with 0x01, so an instruction scan shifts out 1 and then seven 0s. The instruction shifts in LSB first.
- R4: BYPASS (0xFF) selects a 1-bit register that captures 0, so TDO repeats TDI one shift later.
- R5: EXTEST (0x00) and SAMPLE/PRELOAD (0x1C) behave exactly like BYPASS.
- R6: Any opcode that is not a listed instruction selects the bypass register.
- R7: User-signature read (0x17) captures `ues_value` in Capture-DR and shifts it out LSB first.
- R8: Configuration address (0x2B) selects a 4-bit register. It captures the current `cfg_addr` and copies the shifted value to `cfg_addr` in Update-DR. `cfg_addr` changes only in Update-DR.
- R9: Configuration data (0x2D) selects a 56-bit register. It captures `cfg_rd_data` and copies the shifted value to `cfg_wr_data` in Update-DR.
- R10: Command opcodes map onto `cmd_pulse` bits as follows: bit0=0x03, bit1=0x09, bit2=0x14, bit3=0x15, bit4=0x1A, bit5=0x1E, bit6=0x22, bit7=0x24, bit8=0x28, bit9=0x29, bit10=0x2E, bit11=0x2F. The matching bit is high for exactly the first Run-Test/Idle cycle after Update-IR. At all other times the bus is zero, and it stays zero for opcodes that are not commands.
- R11: `tdo_oe` is high only in Shift-IR and Shift-DR. `tdo` and `tdo_oe` change on the falling edge of TCK.
- R12: While a command opcode is active, data scans use the 1-bit bypass path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tap_rst | input | 1 | Synchronous active-high test reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| ues_value | input | UES_W | User-signature value captured for reading |
| cfg_rd_data | input | DATA_W | Parallel value captured by the configuration data register |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdo_oe | output | 1 | Output enable for tdo |
| cfg_addr | output | ADDR_W | Configuration address loaded in Update-DR |
| cfg_wr_data | output | DATA_W | Configuration data loaded in Update-DR |
| cmd_pulse | output | 12 | One-cycle command strobes |

## Verification
The hardest case to reach from the ports is the command strobe. It needs a complete instruction scan, then an Update-IR, then a step into Run-Test/Idle with TMS low, and the strobe has to be seen in that single cycle. The bench walks the TAP through full scans and samples `cmd_pulse` right after the update edge and again one clock later. Reset-through-TMS is reached by loading a bypass instruction first and then holding TMS high for five clocks, so that a following bare data scan can only return the identifier if the instruction really returned to IDCODE.

// File: rtl/tap_pkg.sv
package tap_pkg;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_DR_SEL, ST_DR_CAP, ST_DR_SHIFT, ST_DR_EX1, ST_DR_PAUSE, ST_DR_EX2, ST_DR_UPD,
    ST_IR_SEL, ST_IR_CAP, ST_IR_SHIFT, ST_IR_EX1, ST_IR_PAUSE, ST_IR_EX2, ST_IR_UPD
  } tap_state_e;

  localparam int IR_W  = 8;
  localparam int ID_W  = 32;
  localparam int CMD_N = 12;

  localparam logic [IR_W-1:0] IR_CAPTURE = 8'h01;

  localparam logic [IR_W-1:0] OP_EXTEST   = 8'h00;
  localparam logic [IR_W-1:0] OP_SAMPLE   = 8'h1C;
  localparam logic [IR_W-1:0] OP_BYPASS   = 8'hFF;
  localparam logic [IR_W-1:0] OP_IDCODE   = 8'h16;
  localparam logic [IR_W-1:0] OP_SIG_RD   = 8'h17;
  localparam logic [IR_W-1:0] OP_CFG_ADDR = 8'h2B;
  localparam logic [IR_W-1:0] OP_CFG_DATA = 8'h2D;

  typedef enum logic [2:0] {
    PATH_BYP, PATH_ID, PATH_SIG, PATH_ADDR, PATH_DATA
  } dr_path_e;

  function automatic dr_path_e path_decode(input logic [IR_W-1:0] op);
    case (op)
      OP_IDCODE:   return PATH_ID;
      OP_SIG_RD:   return PATH_SIG;
      OP_CFG_ADDR: return PATH_ADDR;
      OP_CFG_DATA: return PATH_DATA;
      default:     return PATH_BYP;
    endcase
  endfunction

  function automatic logic [CMD_N-1:0] cmd_decode(input logic [IR_W-1:0] op);
    logic [CMD_N-1:0] c;
    c = '0;
    case (op)
      8'h03: c[0]  = 1'b1;
      8'h09: c[1]  = 1'b1;
      8'h14: c[2]  = 1'b1;
      8'h15: c[3]  = 1'b1;
      8'h1A: c[4]  = 1'b1;
      8'h1E: c[5]  = 1'b1;
      8'h22: c[6]  = 1'b1;
      8'h24: c[7]  = 1'b1;
      8'h28: c[8]  = 1'b1;
      8'h29: c[9]  = 1'b1;
      8'h2E: c[10] = 1'b1;
      8'h2F: c[11] = 1'b1;
      default: c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e nxt;

  always_comb begin
    case (state)
      ST_RESET:    nxt = tms ? ST_RESET    : ST_IDLE;
      ST_IDLE:     nxt = tms ? ST_DR_SEL   : ST_IDLE;
      ST_DR_SEL:   nxt = tms ? ST_IR_SEL   : ST_DR_CAP;
      ST_DR_CAP:   nxt = tms ? ST_DR_EX1   : ST_DR_SHIFT;
      ST_DR_SHIFT: nxt = tms ? ST_DR_EX1   : ST_DR_SHIFT;
      ST_DR_EX1:   nxt = tms ? ST_DR_UPD   : ST_DR_PAUSE;
      ST_DR_PAUSE: nxt = tms ? ST_DR_EX2   : ST_DR_PAUSE;
      ST_DR_EX2:   nxt = tms ? ST_DR_UPD   : ST_DR_SHIFT;
      ST_DR_UPD:   nxt = tms ? ST_DR_SEL   : ST_IDLE;
      ST_IR_SEL:   nxt = tms ? ST_RESET    : ST_IR_CAP;
      ST_IR_CAP:   nxt = tms ? ST_IR_EX1   : ST_IR_SHIFT;
      ST_IR_SHIFT: nxt = tms ? ST_IR_EX1   : ST_IR_SHIFT;
      ST_IR_EX1:   nxt = tms ? ST_IR_UPD   : ST_IR_PAUSE;
      ST_IR_PAUSE: nxt = tms ? ST_IR_EX2   : ST_IR_PAUSE;
      ST_IR_EX2:   nxt = tms ? ST_IR_UPD   : ST_IR_SHIFT;
      ST_IR_UPD:   nxt = tms ? ST_DR_SEL   : ST_IDLE;
      default:     nxt = ST_RESET;
    endcase
  end

  always_ff @(posedge tck) begin
    if (rst) state <= ST_RESET;
    else     state <= nxt;
  end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
(
  input  logic             tck,
  input  logic             rst,
  input  logic             tms,
  input  logic             tdi,
  input  tap_state_e       state,
  output logic             ir_so,
  output logic [IR_W-1:0]  ir_active,
  output dr_path_e         path,
  output logic [CMD_N-1:0] cmd_pulse
);

  logic [IR_W-1:0] ir_sr;

  // Instruction shift register: capture pattern, then LSB-first shift
  always_ff @(posedge tck) begin
    if (rst) begin
      ir_sr <= '0;
    end else if (state == ST_IR_CAP) begin
      ir_sr <= IR_CAPTURE;
    end else if (state == ST_IR_SHIFT) begin
      ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end
  end

  // Active instruction and command strobes
  always_ff @(posedge tck) begin
    if (rst) begin
      ir_active <= OP_IDCODE;
      cmd_pulse <= '0;
    end else begin
      cmd_pulse <= '0;
      if (state == ST_RESET) begin
        ir_active <= OP_IDCODE;
      end else if (state == ST_IR_UPD) begin
        ir_active <= ir_sr;
        if (!tms) cmd_pulse <= cmd_decode(ir_sr);
      end
    end
  end

  assign ir_so = ir_sr[0];
  assign path  = path_decode(ir_active);

endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import tap_pkg::*;
#(
  parameter logic [ID_W-1:0] ID_VALUE = 32'h1234_5C43,
  parameter int UES_W  = 32,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 56
) (
  input  logic              tck,
  input  logic              rst,
  input  logic              tdi,
  input  tap_state_e        state,
  input  dr_path_e          path,
  input  logic [UES_W-1:0]  ues_value,
  input  logic [DATA_W-1:0] cfg_rd_data,
  output logic              dr_so,
  output logic [ADDR_W-1:0] cfg_addr,
  output logic [DATA_W-1:0] cfg_wr_data
);

  logic cap, sh, upd;
  assign cap = (state == ST_DR_CAP);
  assign sh  = (state == ST_DR_SHIFT);
  assign upd = (state == ST_DR_UPD);

  logic              byp_q;
  logic [ID_W-1:0]   id_sr;
  logic [UES_W-1:0]  sig_sr;
  logic [ADDR_W-1:0] addr_sr;
  logic [DATA_W-1:0] data_sr;

  always_ff @(posedge tck) begin
    if (rst)                            byp_q <= 1'b0;
    else if (cap && path == PATH_BYP)   byp_q <= 1'b0;
    else if (sh && path == PATH_BYP)    byp_q <= tdi;
  end

  always_ff @(posedge tck) begin
    if (rst)                           id_sr <= '0;
    else if (cap && path == PATH_ID)   id_sr <= ID_VALUE;
    else if (sh && path == PATH_ID)    id_sr <= {tdi, id_sr[ID_W-1:1]};
  end

  always_ff @(posedge tck) begin
    if (rst)                            sig_sr <= '0;
    else if (cap && path == PATH_SIG)   sig_sr <= ues_value;
    else if (sh && path == PATH_SIG)    sig_sr <= {tdi, sig_sr[UES_W-1:1]};
  end

  generate
    if (ADDR_W == 1) begin : g_addr_bit
      always_ff @(posedge tck) begin
        if (rst)                             addr_sr <= '0;
        else if (cap && path == PATH_ADDR)   addr_sr <= cfg_addr;
        else if (sh && path == PATH_ADDR)    addr_sr <= tdi;
      end
    end else begin : g_addr_vec
      always_ff @(posedge tck) begin
        if (rst)                             addr_sr <= '0;
        else if (cap && path == PATH_ADDR)   addr_sr <= cfg_addr;
        else if (sh && path == PATH_ADDR)    addr_sr <= {tdi, addr_sr[ADDR_W-1:1]};
      end
    end
  endgenerate

  always_ff @(posedge tck) begin
    if (rst)                             data_sr <= '0;
    else if (cap && path == PATH_DATA)   data_sr <= cfg_rd_data;
    else if (sh && path == PATH_DATA)    data_sr <= {tdi, data_sr[DATA_W-1:1]};
  end

  // Shadow registers loaded on Update-DR
  always_ff @(posedge tck) begin
    if (rst) begin
      cfg_addr    <= '0;
      cfg_wr_data <= '0;
    end else if (upd) begin
      if (path == PATH_ADDR) cfg_addr    <= addr_sr;
      if (path == PATH_DATA) cfg_wr_data <= data_sr;
    end
  end

  always_comb begin
    case (path)
      PATH_ID:   dr_so = id_sr[0];
      PATH_SIG:  dr_so = sig_sr[0];
      PATH_ADDR: dr_so = addr_sr[0];
      PATH_DATA: dr_so = data_sr[0];
      default:   dr_so = byp_q;
    endcase
  end

endmodule

// File: rtl/tap_port.sv
module tap_port
  import tap_pkg::*;
#(
  parameter logic [31:0] ID_VALUE = 32'h1234_5C43,
  parameter int UES_W  = 32,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 56
) (
  input  logic              tck,
  input  logic              tap_rst,
  input  logic              tms,
  input  logic              tdi,
  input  logic [UES_W-1:0]  ues_value,
  input  logic [DATA_W-1:0] cfg_rd_data,
  output logic              tdo,
  output logic              tdo_oe,
  output logic [ADDR_W-1:0] cfg_addr,
  output logic [DATA_W-1:0] cfg_wr_data,
  output logic [11:0]       cmd_pulse
);

  tap_state_e      tap_state;
  dr_path_e        path;
  logic [IR_W-1:0] ir_active;
  logic            ir_so, dr_so;

  tap_fsm u_fsm (
    .tck   (tck),
    .rst   (tap_rst),
    .tms   (tms),
    .state (tap_state)
  );

  tap_ir u_ir (
    .tck       (tck),
    .rst       (tap_rst),
    .tms       (tms),
    .tdi       (tdi),
    .state     (tap_state),
    .ir_so     (ir_so),
    .ir_active (ir_active),
    .path      (path),
    .cmd_pulse (cmd_pulse)
  );

  tap_dr #(
    .ID_VALUE (ID_VALUE),
    .UES_W    (UES_W),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W)
  ) u_dr (
    .tck         (tck),
    .rst         (tap_rst),
    .tdi         (tdi),
    .state       (tap_state),
    .path        (path),
    .ues_value   (ues_value),
    .cfg_rd_data (cfg_rd_data),
    .dr_so       (dr_so),
    .cfg_addr    (cfg_addr),
    .cfg_wr_data (cfg_wr_data)
  );

  // Output stage on the falling edge of TCK
  always_ff @(negedge tck) begin
    if (tap_rst) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= (tap_state == ST_IR_SHIFT) || (tap_state == ST_DR_SHIFT);
      if (tap_state == ST_IR_SHIFT)      tdo <= ir_so;
      else if (tap_state == ST_DR_SHIFT) tdo <= dr_so;
    end
  end

endmodule

// File: rtl/tap_port_chk.sv
module tap_port_chk
  import tap_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              tck,
  input logic              tap_rst,
  input tap_state_e        tap_state,
  input logic [IR_W-1:0]   ir_active,
  input logic              tdo_oe,
  input logic [CMD_N-1:0]  cmd_pulse,
  input logic [ADDR_W-1:0] cfg_addr
);

  AST_CMD_ONEHOT: assert property (@(posedge tck) disable iff (tap_rst)
    $onehot0(cmd_pulse)); // R10

  AST_CMD_SINGLE: assert property (@(posedge tck) disable iff (tap_rst)
    (cmd_pulse != '0) |=> (cmd_pulse == '0)); // R10

  AST_CMD_AFTER_UPDATE: assert property (@(posedge tck) disable iff (tap_rst)
    (cmd_pulse != '0) |-> (tap_state == ST_IDLE && $past(tap_state) == ST_IR_UPD)); // R10

  AST_OE_IN_SHIFT: assert property (@(posedge tck) disable iff (tap_rst)
    tdo_oe |-> (tap_state == ST_IR_SHIFT || tap_state == ST_DR_SHIFT)); // R11

  AST_RESET_IDCODE: assert property (@(posedge tck) disable iff (tap_rst)
    (tap_state == ST_RESET) |=> (ir_active == OP_IDCODE)); // R1

  AST_ADDR_HOLD: assert property (@(posedge tck) disable iff (tap_rst)
    (tap_state != ST_DR_UPD) |=> $stable(cfg_addr)); // R8

endmodule

bind tap_port tap_port_chk #(.ADDR_W(ADDR_W)) u_chk (
  .tck       (tck),
  .tap_rst   (tap_rst),
  .tap_state (tap_state),
  .ir_active (ir_active),
  .tdo_oe    (tdo_oe),
  .cmd_pulse (cmd_pulse),
  .cfg_addr  (cfg_addr)
);

// File: tb/tap_port_tb.sv
`timescale 1ns/100ps
module tap_port_tb;

  localparam logic [31:0] TB_ID = 32'h0A5B_3C2D | 32'h1;

  logic        tck = 1'b0;
  logic        tap_rst = 1'b1;
  logic        tms = 1'b1;
  logic        tdi = 1'b0;
  logic [31:0] ues_value = '0;
  logic [55:0] cfg_rd_data = '0;
  logic        tdo, tdo_oe;
  logic [3:0]  cfg_addr;
  logic [55:0] cfg_wr_data;
  logic [11:0] cmd_pulse;

  always #2.5 tck = ~tck;

  tap_port #(.ID_VALUE(TB_ID)) u_dut (
    .tck(tck), .tap_rst(tap_rst), .tms(tms), .tdi(tdi),
    .ues_value(ues_value), .cfg_rd_data(cfg_rd_data),
    .tdo(tdo), .tdo_oe(tdo_oe), .cfg_addr(cfg_addr),
    .cfg_wr_data(cfg_wr_data), .cmd_pulse(cmd_pulse)
  );

  typedef struct {
    logic [63:0] v;
    string       tag;
  } item_t;

  item_t exp_q[$];
  item_t act_q[$];
  int n_chk = 0;
  int n_fail = 0;
  logic finished = 1'b0;
  logic shift_oe;

  // Driver side: expected value first, then observed value
  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    item_t e, a;
    e.v = exp; e.tag = tag;
    a.v = act; a.tag = tag;
    exp_q.push_back(e);
    act_q.push_back(a);
  endtask

  // Monitor: pops and compares
  initial begin
    forever begin
      item_t e, a;
      wait (act_q.size() > 0 && exp_q.size() > 0);
      e = exp_q.pop_front();
      a = act_q.pop_front();
      n_chk++;
      if (a.v !== e.v) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", e.tag, a.v, e.v);
      end
    end
  end

  task automatic step(input logic m, input logic d);
    tms = m;
    tdi = d;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  task automatic scan_ir(input logic [7:0] op, output logic [7:0] out);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 8; i++) begin
      out[i] = tdo;
      step(i == 7, op[i]);
    end
    step(1, 0);
    step(0, 0);
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] out);
    out = '0;
    step(1, 0); step(0, 0); step(0, 0);
    shift_oe = tdo_oe;
    for (int i = 0; i < n; i++) begin
      out[i] = tdo;
      step(i == n - 1, din[i]);
    end
    step(1, 0);
    step(0, 0);
  endtask

  initial begin
    repeat (20000) @(posedge tck);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0]  ir_out;
    logic [63:0] dr_out;

    repeat (3) @(posedge tck);
    @(negedge tck); #1;
    tap_rst = 1'b0;
    // R1: reset state at ports
    check("R1 oe after reset", {63'd0, tdo_oe}, 64'd0);
    check("R1 cmd after reset", {52'd0, cmd_pulse}, 64'd0);
    step(0, 0);

    // R2: identifier without instruction scan
    scan_dr(32, 64'd0, dr_out);
    check("R2 idcode after reset", dr_out, {32'd0, TB_ID});
    check("R11 oe high in shift", {63'd0, shift_oe}, 64'd1);
    check("R11 oe low in idle", {63'd0, tdo_oe}, 64'd0);

    // R3 + R4: capture pattern, bypass
    scan_ir(8'hFF, ir_out);
    check("R3 ir capture", {56'd0, ir_out}, 64'h01);
    scan_dr(8, 64'hB5, dr_out);
    check("R4 bypass", dr_out, 64'h6A);

    // R5: boundary-scan opcodes fall back to bypass
    scan_ir(8'h00, ir_out);
    scan_dr(8, 64'h3C, dr_out);
    check("R5 extest bypass", dr_out, 64'h78);
    scan_ir(8'h1C, ir_out);
    scan_dr(8, 64'hC3, dr_out);
    check("R5 sample bypass", dr_out, 64'h86);

    // R6: unlisted opcode
    scan_ir(8'h55, ir_out);
    check("R10 no strobe for 0x55", {52'd0, cmd_pulse}, 64'd0);
    scan_dr(8, 64'h81, dr_out);
    check("R6 unknown bypass", dr_out, 64'h02);

    // R7: user signature
    ues_value = 32'hCAFE_0123;
    scan_ir(8'h17, ir_out);
    scan_dr(32, 64'd0, dr_out);
    check("R7 signature read", dr_out, 64'hCAFE_0123);

    // R8: address register
    scan_ir(8'h2B, ir_out);
    scan_dr(4, 64'hA, dr_out);
    check("R8 addr capture reset", dr_out, 64'h0);
    check("R8 addr update", {60'd0, cfg_addr}, 64'hA);
    scan_dr(4, 64'h3, dr_out);
    check("R8 addr capture held", dr_out, 64'hA);
    check("R8 addr update 2", {60'd0, cfg_addr}, 64'h3);

    // R9: configuration data register
    cfg_rd_data = 56'h12_3456_789A_BCDE;
    scan_ir(8'h2D, ir_out);
    check("R10 no strobe for 0x2D", {52'd0, cmd_pulse}, 64'd0);
    scan_dr(56, 64'hA5_5A00_FF11_2233, dr_out);
    check("R9 data capture", dr_out, 64'h12_3456_789A_BCDE);
    check("R9 data update", {8'd0, cfg_wr_data}, 64'hA5_5A00_FF11_2233);

    // R8: bypass scans leave the address alone
    scan_ir(8'hFF, ir_out);
    scan_dr(4, 64'hF, dr_out);
    check("R8 addr untouched", {60'd0, cfg_addr}, 64'h3);

    // R10: command strobes
    scan_ir(8'h03, ir_out);
    check("R10 bulk erase strobe", {52'd0, cmd_pulse}, 64'h001);
    step(0, 0);
    check("R10 strobe one cycle", {52'd0, cmd_pulse}, 64'd0);
    scan_ir(8'h28, ir_out);
    check("R10 verify strobe", {52'd0, cmd_pulse}, 64'h100);
    step(0, 0);
    check("R10 verify clears", {52'd0, cmd_pulse}, 64'd0);
    // R12: command opcode uses bypass
    scan_dr(8, 64'h0F, dr_out);
    check("R12 command bypass", dr_out, 64'h1E);
    check("R10 no strobe after dr scan", {52'd0, cmd_pulse}, 64'd0);
    scan_ir(8'h2F, ir_out);
    check("R10 done-bit strobe", {52'd0, cmd_pulse}, 64'h800);
    scan_ir(8'h1A, ir_out);
    check("R10 signature program strobe", {52'd0, cmd_pulse}, 64'h010);

    // R1: five TMS high returns to IDCODE
    scan_ir(8'hFF, ir_out);
    for (int k = 0; k < 5; k++) step(1, 0);
    check("R1 oe in tms reset", {63'd0, tdo_oe}, 64'd0);
    check("R1 cmd in tms reset", {52'd0, cmd_pulse}, 64'd0);
    step(0, 0);
    scan_dr(32, 64'd0, dr_out);
    check("R1 idcode after tms reset", dr_out, {32'd0, TB_ID});

    wait (act_q.size() == 0);
    #1;
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule